// File: doc/BRIEF.md
# Bank Controller with Latched Real-Time Clock

This block sits between a CPU and a cartridge's ROM and RAM. It holds the ROM bank and RAM bank numbers that place the switchable windows, and turns them into base offsets for the memory address path. It also keeps a real-time clock made of seconds, minutes, hours and a 9-bit day count. The clock moves forward by one second on each pulse of a once-per-second tick input.

A single select register is shared between RAM banks and clock registers. Small select values pick a RAM bank. Larger values, accepted only while RAM is enabled, map one clock register into the RAM window in place of RAM. The CPU never reads the live counters directly. A two-step latch command, writing 0 and then 1, freezes a snapshot of the whole clock, and window reads return that snapshot. Window writes in clock mode go to the live counters.

The CPU port decodes the upper three address bits. In the control area, bits 14:13 pick the register: 0 is RAM enable, 1 is ROM bank, 2 is select and 3 is latch. The pattern 3'b101 is the RAM window. The latch command is tracked by a two-state machine. LATCH_ARMED is the reset state and means the last latch value seen was 0. LATCH_IDLE means the last value seen was 1. Writing 0 takes ARMED/IDLE to ARMED. Writing 1 in ARMED captures the snapshot and moves to IDLE. Writing 1 in IDLE stays in IDLE without a capture. Any other value leaves the state as it is.

Top module: `rtc_bank_ctrl`

## Requirements
- R1: The ROM bank register keeps the low 7 bits of a write, and a masked value of 0 is stored as 1. `rom_base` is the bank shifted left by 14. After reset the bank is 1.
- R2: A select write with a value below 8 stores a RAM bank and returns the window to RAM mode. `ram_base` equals the value shifted left by 13. Writes of any other value leave `ram_base` unchanged.
- R3: RAM becomes enabled when a write has both bit 1 and bit 3 set, and disabled by any other write. While RAM is disabled, `ram_window_en` is 0 and `clock_rd` is 0.
- R4: A select write of 8 or above puts the window in clock mode only while RAM is enabled. In clock mode `ram_window_en` is 0. While RAM is disabled, such a write is ignored. Codes: 0x08 seconds, 0x09 minutes, 0x0A hours, 0x0B day bits 7:0, 0x0C control (bit 7 carry flag, bits 6:1 stored, bit 0 day bit 8). Any other code reads 0.
- R5: A latch write of 1 captures all live clock fields when the previous latch value was 0, and reset counts as a previous 0. A repeated 1 does not capture. Values other than 0 and 1 do not change the remembered latch value.
- R6: `clock_rd` returns the snapshot of the selected field. Ticks and live writes do not change it until the next capture.
- R7: Each tick adds one second. Seconds and minutes wrap from 59 to 0 and hours wrap from 23 to 0, each carrying into the next field.
- R8: The day count is 9 bits wide. A carry out of day 511 wraps it to 0 and sets control bit 7, which stays set until reset.
- R9: A CPU write to the control register keeps bit 7 set if it was already set, and otherwise takes bit 7 from the written value.
- R10: A window write to a live clock field in the same cycle as a tick takes priority, and that tick is dropped.
- R11: Window writes in clock mode while RAM is enabled load the selected live field: seconds 6 bits, minutes 6 bits, hours 5 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one cycle per write |
| cpu_addr_hi | input | 3 | CPU address bits 15:13 |
| cpu_wdata | input | 8 | CPU write data |
| tick | input | 1 | One-cycle pulse per elapsed second |
| rom_base | output | 21 | Byte offset of the switchable ROM window |
| ram_base | output | 16 | Byte offset of the selected RAM bank |
| ram_window_en | output | 1 | External RAM is reachable through the window |
| clock_rd | output | 8 | Window read data for the selected clock register |

## Verification
The bench uses the default parameters: a 7-bit ROM bank and a 3-bit RAM bank. These let it reach the top ROM bank 0x7F, the zero-to-one substitution, every RAM bank offset, and the boundary between RAM select values and clock codes at 8. The clock limits are fixed at 60, 60, 24 and 512. The bench reaches the 23:59:59 carry chain and the day-511 rollover by loading the live fields through window writes and then sending a single tick, so no long run is needed. Every result is read back through the latch command and the window read data.

// File: rtl/rtc_bank_pkg.sv
package rtc_bank_pkg;

    typedef enum logic [1:0] {
        LATCH_ARMED = 2'd0,
        LATCH_IDLE  = 2'd1
    } latch_state_t;

    typedef enum logic [1:0] {
        REG_ENABLE  = 2'd0,
        REG_ROMBANK = 2'd1,
        REG_SELECT  = 2'd2,
        REG_LATCH   = 2'd3
    } ctrl_reg_t;

    localparam logic [2:0] WINDOW_REGION = 3'b101;

    localparam logic [7:0] CODE_SEC  = 8'h08;
    localparam logic [7:0] CODE_MIN  = 8'h09;
    localparam logic [7:0] CODE_HR   = 8'h0A;
    localparam logic [7:0] CODE_DAYL = 8'h0B;
    localparam logic [7:0] CODE_CTRL = 8'h0C;

    localparam int SEC_W = 6;
    localparam int MIN_W = 6;
    localparam int HR_W  = 5;
    localparam int DAY_W = 9;

    localparam logic [SEC_W-1:0] SEC_LAST = 6'd59;
    localparam logic [MIN_W-1:0] MIN_LAST = 6'd59;
    localparam logic [HR_W-1:0]  HR_LAST  = 5'd23;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [MIN_W-1:0] min;
        logic [HR_W-1:0]  hr;
        logic [DAY_W-1:0] day;
        logic [6:0]       ctrl_hi;
    } clock_fields_t;

endpackage

// File: rtl/rtc_bank_map.sv
module rtc_bank_map
    import rtc_bank_pkg::*;
#(
    parameter int ROM_BANK_W = 7,
    parameter int RAM_BANK_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctrl_wr,
    input  ctrl_reg_t             ctrl_reg,
    input  logic [7:0]            wdata,
    output logic                  ram_en,
    output logic [ROM_BANK_W-1:0] rom_bank,
    output logic [RAM_BANK_W-1:0] ram_bank,
    output logic                  clock_mode,
    output logic [7:0]            clock_code
);
    localparam logic [ROM_BANK_W-1:0] ROM_BANK_ONE = {{(ROM_BANK_W-1){1'b0}}, 1'b1};

    logic                  sel_is_ram;
    logic [ROM_BANK_W-1:0] rom_masked;

    assign sel_is_ram = ((wdata >> RAM_BANK_W) == 8'd0);
    assign rom_masked = wdata[ROM_BANK_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_en     <= 1'b0;
            rom_bank   <= ROM_BANK_ONE;
            ram_bank   <= '0;
            clock_mode <= 1'b0;
            clock_code <= CODE_SEC;
        end else if (ctrl_wr) begin
            unique case (ctrl_reg)
                REG_ENABLE:  ram_en <= wdata[1] & wdata[3];
                REG_ROMBANK: rom_bank <= (rom_masked == '0) ? ROM_BANK_ONE : rom_masked;
                REG_SELECT: begin
                    if (sel_is_ram) begin
                        ram_bank   <= wdata[RAM_BANK_W-1:0];
                        clock_mode <= 1'b0;
                    end else if (ram_en) begin
                        clock_mode <= 1'b1;
                        clock_code <= wdata;
                    end
                end
                REG_LATCH: ;
            endcase
        end
    end
endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper
    import rtc_bank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [7:0]    wr_code,
    input  logic [7:0]    wr_data,
    output clock_fields_t live
);
    localparam logic [DAY_W-1:0] DAY_LAST = '1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live <= '0;
        end else if (wr_en) begin
            case (wr_code)
                CODE_SEC:  live.sec <= wr_data[SEC_W-1:0];
                CODE_MIN:  live.min <= wr_data[MIN_W-1:0];
                CODE_HR:   live.hr  <= wr_data[HR_W-1:0];
                CODE_DAYL: live.day[7:0] <= wr_data;
                CODE_CTRL: begin
                    live.day[DAY_W-1] <= wr_data[0];
                    live.ctrl_hi      <= wr_data[7:1] | {live.ctrl_hi[6], 6'd0};
                end
                default: ;
            endcase
        end else if (tick) begin
            if (live.sec >= SEC_LAST) begin
                live.sec <= '0;
                if (live.min >= MIN_LAST) begin
                    live.min <= '0;
                    if (live.hr >= HR_LAST) begin
                        live.hr <= '0;
                        if (live.day == DAY_LAST) begin
                            live.day        <= '0;
                            live.ctrl_hi[6] <= 1'b1;
                        end else begin
                            live.day <= live.day + 1'b1;
                        end
                    end else begin
                        live.hr <= live.hr + 1'b1;
                    end
                end else begin
                    live.min <= live.min + 1'b1;
                end
            end else begin
                live.sec <= live.sec + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rtc_latch_seq.sv
module rtc_latch_seq
    import rtc_bank_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          latch_wr,
    input  logic [7:0]    latch_val,
    input  clock_fields_t live,
    output clock_fields_t snap
);
    latch_state_t state, state_nxt;
    logic         capture;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= LATCH_ARMED;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        capture   = 1'b0;
        if (latch_wr) begin
            unique case (state)
                LATCH_ARMED: begin
                    if (latch_val == 8'd1) begin
                        capture   = 1'b1;
                        state_nxt = LATCH_IDLE;
                    end
                end
                LATCH_IDLE: begin
                    if (latch_val == 8'd0) state_nxt = LATCH_ARMED;
                end
                default: state_nxt = LATCH_ARMED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)       snap <= '0;
        else if (capture) snap <= live;
    end
endmodule

// File: rtl/rtc_bank_ctrl.sv
module rtc_bank_ctrl
    import rtc_bank_pkg::*;
#(
    parameter int ROM_BANK_W     = 7,
    parameter int RAM_BANK_W     = 3,
    parameter int ROM_PAGE_SHIFT = 14,
    parameter int RAM_PAGE_SHIFT = 13,
    localparam int ROM_BASE_W    = ROM_BANK_W + ROM_PAGE_SHIFT,
    localparam int RAM_BASE_W    = RAM_BANK_W + RAM_PAGE_SHIFT
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cpu_wr,
    input  logic [2:0]            cpu_addr_hi,
    input  logic [7:0]            cpu_wdata,
    input  logic                  tick,
    output logic [ROM_BASE_W-1:0] rom_base,
    output logic [RAM_BASE_W-1:0] ram_base,
    output logic                  ram_window_en,
    output logic [7:0]            clock_rd
);
    logic                  ctrl_wr, win_wr, latch_wr;
    ctrl_reg_t             ctrl_reg;
    logic                  map_en, clock_mode;
    logic [ROM_BANK_W-1:0] rom_bank;
    logic [RAM_BANK_W-1:0] ram_bank;
    logic [7:0]            clock_code;
    clock_fields_t         live, snap;

    assign ctrl_wr  = cpu_wr & ~cpu_addr_hi[2];
    assign ctrl_reg = ctrl_reg_t'(cpu_addr_hi[1:0]);
    assign latch_wr = ctrl_wr & (ctrl_reg == REG_LATCH);
    assign win_wr   = cpu_wr & (cpu_addr_hi == WINDOW_REGION) & map_en & clock_mode;

    rtc_bank_map #(.ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W)) u_map (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_reg(ctrl_reg),
        .wdata(cpu_wdata), .ram_en(map_en), .rom_bank(rom_bank),
        .ram_bank(ram_bank), .clock_mode(clock_mode), .clock_code(clock_code)
    );

    rtc_timekeeper u_time (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(win_wr),
        .wr_code(clock_code), .wr_data(cpu_wdata), .live(live)
    );

    rtc_latch_seq u_latch (
        .clk(clk), .rst_n(rst_n), .latch_wr(latch_wr), .latch_val(cpu_wdata),
        .live(live), .snap(snap)
    );

    assign rom_base      = {rom_bank, {ROM_PAGE_SHIFT{1'b0}}};
    assign ram_base      = {ram_bank, {RAM_PAGE_SHIFT{1'b0}}};
    assign ram_window_en = map_en & ~clock_mode;

    always_comb begin
        clock_rd = 8'd0;
        if (map_en && clock_mode) begin
            case (clock_code)
                CODE_SEC:  clock_rd = {2'd0, snap.sec};
                CODE_MIN:  clock_rd = {2'd0, snap.min};
                CODE_HR:   clock_rd = {3'd0, snap.hr};
                CODE_DAYL: clock_rd = snap.day[7:0];
                CODE_CTRL: clock_rd = {snap.ctrl_hi, snap.day[DAY_W-1]};
                default:   clock_rd = 8'd0;
            endcase
        end
    end
endmodule

// File: rtl/rtc_bank_ctrl_chk.sv
module rtc_bank_ctrl_chk #(
    parameter int ROM_BANK_W     = 7,
    parameter int RAM_BANK_W     = 3,
    parameter int ROM_PAGE_SHIFT = 14,
    parameter int RAM_PAGE_SHIFT = 13
) (
    input logic                                 clk,
    input logic                                 rst_n,
    input logic                                 cpu_wr,
    input logic [2:0]                           cpu_addr_hi,
    input logic [7:0]                           cpu_wdata,
    input logic [ROM_BANK_W+ROM_PAGE_SHIFT-1:0] rom_base,
    input logic [RAM_BANK_W+RAM_PAGE_SHIFT-1:0] ram_base,
    input logic                                 ram_window_en,
    input logic [7:0]                           clock_rd,
    input logic                                 ram_en,
    input logic                                 carry_flag
);
    logic rom_wr, ram_sel_wr;
    assign rom_wr     = cpu_wr && (cpu_addr_hi == 3'b001);
    assign ram_sel_wr = cpu_wr && (cpu_addr_hi == 3'b010) && (cpu_wdata[7:3] == 5'd0);

    // R1: bank never zero, page-aligned
    assert_rom_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_base[ROM_BANK_W+ROM_PAGE_SHIFT-1:ROM_PAGE_SHIFT] != '0) &&
        (rom_base[ROM_PAGE_SHIFT-1:0] == '0));

    assert_rom_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rom_wr |=> $stable(rom_base));

    assert_ram_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_sel_wr |=> $stable(ram_base));

    assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_en |-> (!ram_window_en && clock_rd == 8'd0));

    assert_snapshot_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_wr |=> $stable(clock_rd));

    assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        carry_flag |=> carry_flag);
endmodule

bind rtc_bank_ctrl rtc_bank_ctrl_chk #(
    .ROM_BANK_W(ROM_BANK_W), .RAM_BANK_W(RAM_BANK_W),
    .ROM_PAGE_SHIFT(ROM_PAGE_SHIFT), .RAM_PAGE_SHIFT(RAM_PAGE_SHIFT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr_hi(cpu_addr_hi),
    .cpu_wdata(cpu_wdata), .rom_base(rom_base), .ram_base(ram_base),
    .ram_window_en(ram_window_en), .clock_rd(clock_rd),
    .ram_en(map_en), .carry_flag(live.ctrl_hi[6])
);

// File: tb/rtc_bank_ctrl_bench.sv
module rtc_bank_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [2:0]  cpu_addr_hi = 3'd0;
    logic [7:0]  cpu_wdata = 8'd0;
    logic        tick = 1'b0;
    logic [20:0] rom_base;
    logic [15:0] ram_base;
    logic        ram_window_en;
    logic [7:0]  clock_rd;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [2:0] A_EN = 3'd0, A_ROM = 3'd1, A_SEL = 3'd2, A_LAT = 3'd3, A_WIN = 3'd5;

    always #4 clk = ~clk;

    rtc_bank_ctrl u_rtc_bank_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr_hi(cpu_addr_hi),
        .cpu_wdata(cpu_wdata), .tick(tick), .rom_base(rom_base), .ram_base(ram_base),
        .ram_window_en(ram_window_en), .clock_rd(clock_rd)
    );

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr_hi = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic wr_tick(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr_hi = a; cpu_wdata = d; tick = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; tick = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic set_field(input logic [7:0] code, input logic [7:0] d);
        wr(A_SEL, code);
        wr(A_WIN, d);
    endtask

    task automatic latch_now();
        wr(A_LAT, 8'd0);
        wr(A_LAT, 8'd1);
    endtask

    task automatic expect_field(input logic [7:0] code, input logic [7:0] exp, input string req);
        wr(A_SEL, code);
        check(clock_rd == exp, req, clock_rd, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        check(rom_base == 21'h1 << 14, "R1 reset bank", rom_base, 21'h1 << 14);
        check(ram_base == 16'd0, "R2 reset", ram_base, 0);
        check(ram_window_en == 1'b0, "R3 reset disabled", ram_window_en, 0);
        check(clock_rd == 8'd0, "R3 reset read", clock_rd, 0);
    endtask

    task automatic t_rom_bank();
        wr(A_ROM, 8'h00);
        check(rom_base == 21'h1 << 14, "R1 zero->1", rom_base, 21'h1 << 14);
        wr(A_ROM, 8'h85);
        check(rom_base == 21'h05 << 14, "R1 mask 7 bits", rom_base, 21'h05 << 14);
        wr(A_ROM, 8'h7F);
        check(rom_base == 21'h7F << 14, "R1 top bank", rom_base, 21'h7F << 14);
        wr(A_ROM, 8'h80);
        check(rom_base == 21'h1 << 14, "R1 masked zero->1", rom_base, 21'h1 << 14);
    endtask

    task automatic t_enable_and_ram();
        wr(A_EN, 8'h0A);
        check(ram_window_en == 1'b1, "R3 enable 0x0A", ram_window_en, 1);
        wr(A_EN, 8'h08);
        check(ram_window_en == 1'b0, "R3 bit1 missing", ram_window_en, 0);
        wr(A_EN, 8'hFA);
        check(ram_window_en == 1'b1, "R3 enable 0xFA", ram_window_en, 1);
        wr(A_EN, 8'h02);
        check(ram_window_en == 1'b0, "R3 bit3 missing", ram_window_en, 0);
        wr(A_SEL, 8'h05);
        check(ram_base == 16'h5 << 13, "R2 bank 5", ram_base, 16'h5 << 13);
        wr(A_SEL, 8'h07);
        check(ram_base == 16'h7 << 13, "R2 bank 7", ram_base, 16'h7 << 13);
    endtask

    task automatic t_clock_select();
        wr(A_SEL, 8'h08);
        wr(A_EN, 8'h0A);
        check(ram_window_en == 1'b1, "R4 select ignored when disabled", ram_window_en, 1);
        wr(A_SEL, 8'h08);
        check(ram_window_en == 1'b0, "R4 clock mode", ram_window_en, 0);
        check(ram_base == 16'h7 << 13, "R2 bank kept in clock mode", ram_base, 16'h7 << 13);
        wr(A_SEL, 8'h03);
        check(ram_window_en == 1'b1 && ram_base == 16'h3 << 13, "R2 back to RAM", ram_base, 16'h3 << 13);
    endtask

    task automatic t_write_latch();
        set_field(8'h08, 8'd30);
        set_field(8'h09, 8'd45);
        set_field(8'h0A, 8'd13);
        set_field(8'h0B, 8'h34);
        set_field(8'h0C, 8'h41);
        latch_now();
        expect_field(8'h08, 8'd30, "R11 seconds");
        expect_field(8'h09, 8'd45, "R11 minutes");
        expect_field(8'h0A, 8'd13, "R11 hours");
        expect_field(8'h0B, 8'h34, "R11 day low");
        expect_field(8'h0C, 8'h41, "R4 control layout");
        expect_field(8'h0D, 8'h00, "R4 unmapped code");
    endtask

    task automatic t_snapshot();
        wr(A_SEL, 8'h08);
        repeat (3) pulse_tick();
        check(clock_rd == 8'd30, "R6 snapshot frozen", clock_rd, 30);
        wr(A_LAT, 8'd1);
        check(clock_rd == 8'd30, "R5 repeated 1 no capture", clock_rd, 30);
        wr(A_LAT, 8'd0);
        wr(A_LAT, 8'd5);
        wr(A_LAT, 8'd1);
        check(clock_rd == 8'd33, "R5 0,5,1 captures", clock_rd, 33);
        pulse_tick();
        wr(A_LAT, 8'd0);
        wr(A_LAT, 8'd2);
        wr(A_LAT, 8'd1);
        check(clock_rd == 8'd34, "R5 other value keeps armed", clock_rd, 34);
    endtask

    task automatic t_carry_chain();
        set_field(8'h08, 8'd59);
        set_field(8'h09, 8'd59);
        set_field(8'h0A, 8'd23);
        set_field(8'h0B, 8'h10);
        set_field(8'h0C, 8'h00);
        pulse_tick();
        latch_now();
        expect_field(8'h08, 8'd0, "R7 sec wrap");
        expect_field(8'h09, 8'd0, "R7 min wrap");
        expect_field(8'h0A, 8'd0, "R7 hour wrap");
        expect_field(8'h0B, 8'h11, "R7 day carry");
        set_field(8'h08, 8'd59);
        set_field(8'h09, 8'd7);
        pulse_tick();
        latch_now();
        expect_field(8'h09, 8'd8, "R7 minute carry only");
    endtask

    task automatic t_day_rollover();
        set_field(8'h08, 8'd59);
        set_field(8'h09, 8'd59);
        set_field(8'h0A, 8'd23);
        set_field(8'h0B, 8'hFF);
        set_field(8'h0C, 8'h01);
        pulse_tick();
        latch_now();
        expect_field(8'h0B, 8'h00, "R8 day wraps");
        expect_field(8'h0C, 8'h80, "R8 carry flag set");
        set_field(8'h0C, 8'h00);
        latch_now();
        expect_field(8'h0C, 8'h80, "R9 flag kept on write");
        do_reset();
        wr(A_EN, 8'h0A);
        latch_now();
        expect_field(8'h0C, 8'h00, "R8 cleared by reset");
        set_field(8'h0C, 8'h80);
        latch_now();
        expect_field(8'h0C, 8'h80, "R9 flag set by write");
    endtask

    task automatic t_priority();
        set_field(8'h08, 8'd10);
        wr_tick(A_WIN, 8'd20);
        latch_now();
        expect_field(8'h08, 8'd20, "R10 write beats tick");
        pulse_tick();
        latch_now();
        expect_field(8'h08, 8'd21, "R10 later tick counts");
    endtask

    task automatic t_disabled();
        wr(A_SEL, 8'h08);
        wr(A_EN, 8'h00);
        check(clock_rd == 8'd0, "R3 disabled read 0", clock_rd, 0);
        wr(A_WIN, 8'd44);
        wr(A_EN, 8'h0A);
        latch_now();
        check(clock_rd == 8'd21, "R11 write ignored when disabled", clock_rd, 21);
    endtask

    initial begin
        t_reset();
        t_rom_bank();
        t_enable_and_ram();
        t_clock_select();
        t_write_latch();
        t_snapshot();
        t_carry_chain();
        t_day_rollover();
        t_priority();
        t_disabled();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule